// File: doc/BRIEF.md
# PRBS Pattern Lock Monitor

This block watches a stream of ADC sample words and decides whether they follow a pseudo-random reference sequence. Each valid sample is a window of `DATA_W` consecutive sequence bits. The oldest bit sits at the MSB and the newest at bit 0. The monitor forms the word it expects next from a reference LFSR state, compares it with the received word, and keeps a lock status with hysteresis. Software selects one of two sequences through a one-bit type input.

The block does not need a seed. While out of sync, the reference state reloads from every received word, so it picks up the phase of the incoming stream. Once locked, the reference free-runs, so a single corrupted word shows up as a single mismatch. Mismatches seen while locked raise a sticky error flag. Software clears that flag with a write-one pulse. Mismatches seen during acquisition are not reported.

Top module: `prbs_lock_monitor`

## Requirements
- R1: After reset, `oos` and `err_flag` are 0 and the selected type is PN9. The reference state is all zeros, and the block counts as locked.
- R2: `pn_sel` = 0 selects PN9, where b[k] = b[k-9] xor b[k-5]. `pn_sel` = 1 selects PN23, where b[k] = b[k-23] xor b[k-18]. Each sample word carries `DATA_W` (at least 23) consecutive bits, oldest at the MSB and newest at bit 0, and the reference state is the newest 23 bits.
- R3: Under PN23 the received word is bit-inverted before it is compared. Under PN9 it is compared as received.
- R4: While `oos` is 1, `oos` clears in the cycle after the 16th consecutive matching sample.
- R5: While `oos` is 0, `oos` sets in the cycle after the 64th consecutive mismatching sample.
- R6: A match clears the mismatch run, and a mismatch clears the match run.
- R7: `err_flag` sets in the cycle after a mismatch that occurs while `oos` is 0. A mismatch while `oos` is 1 leaves it unchanged.
- R8: `err_flag` stays set until an `err_clr` pulse. When a new locked mismatch arrives in the same cycle as `err_clr`, the flag stays set.
- R9: Samples with `smp_vld` low have no effect on the runs, the reference state or `oos`.
- R10: While `oos` is 1, the reference state reloads from each received (possibly inverted) word. While `oos` is 0, it advances along its own sequence.
- R11: In a cycle where `pn_sel` differs from its registered value, both runs clear and the sample offered in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample word is valid this cycle |
| smp_data | input | DATA_W | Sample word, oldest sequence bit at MSB |
| pn_sel | input | 1 | Sequence type: 0 PN9, 1 PN23 |
| err_clr | input | 1 | Write-one pulse clearing the error flag |
| oos | output | 1 | Out of sync with the reference sequence |
| err_flag | output | 1 | Sticky flag for mismatches seen while locked |

## Verification
The hardest states to reach are the exact hysteresis edges. One is a locked monitor that has seen 63 mismatches, where one good word must reset the run. The other is an unlocked monitor whose reference was reseeded from a corrupted word. The stimulus drives the true sequence from an independent bit generator and corrupts single words by flipping bit 0. The free-running reference therefore stays aligned through long bad runs, and the boundary counts 15, 16, 63 and 64 land on planned cycles. Type changes are offered together with valid samples to show that the sample is discarded and the runs restart.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  // reference state width: enough history for the longer sequence
  localparam int ST_W = 23;

  typedef enum logic {
    PN_9  = 1'b0,
    PN_23 = 1'b1
  } pn_kind_e;

  // next sequence bit from the state; s[0] is the newest bit
  function automatic logic pn_fb(logic [ST_W-1:0] s, pn_kind_e k);
    if (k == PN_23) return s[22] ^ s[17];
    else            return s[8] ^ s[4];
  endfunction

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_mon_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              reseed,
  input  pn_kind_e          kind,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] exp_word
);

  logic [ST_W-1:0] st_q;

  // unroll DATA_W steps of the LFSR; first produced bit lands at the MSB
  function automatic logic [DATA_W-1:0] gen_word(logic [ST_W-1:0] s0, pn_kind_e k);
    logic [ST_W-1:0]   s;
    logic              nb;
    logic [DATA_W-1:0] w;
    s = s0;
    w = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      nb   = pn_fb(s, k);
      w[i] = nb;
      s    = {s[ST_W-2:0], nb};
    end
    return w;
  endfunction

  assign exp_word = gen_word(st_q, kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (adv) begin
      st_q <= reseed ? rx_word[ST_W-1:0] : exp_word[ST_W-1:0];
    end
  end

endmodule

// File: rtl/prbs_hyst.sv
module prbs_hyst #(
  parameter int LOCK_CNT = 16,
  parameter int DROP_CNT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  input  logic miss,
  output logic oos
);

  localparam int MC_W = $clog2(LOCK_CNT + 1);
  localparam int XC_W = $clog2(DROP_CNT + 1);
  localparam logic [MC_W-1:0] MC_TOP  = MC_W'(LOCK_CNT);
  localparam logic [MC_W-1:0] MC_LAST = MC_W'(LOCK_CNT - 1);
  localparam logic [XC_W-1:0] XC_TOP  = XC_W'(DROP_CNT);
  localparam logic [XC_W-1:0] XC_LAST = XC_W'(DROP_CNT - 1);

  logic [MC_W-1:0] mc_q;
  logic [XC_W-1:0] xc_q;
  logic            oos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q  <= '0;
      xc_q  <= '0;
      oos_q <= 1'b0;
    end else if (clr) begin
      mc_q <= '0;
      xc_q <= '0;
    end else if (hit) begin
      xc_q <= '0;
      if (mc_q != MC_TOP) mc_q <= mc_q + MC_W'(1);
      if (oos_q && mc_q == MC_LAST) oos_q <= 1'b0;
    end else if (miss) begin
      mc_q <= '0;
      if (xc_q != XC_TOP) xc_q <= xc_q + XC_W'(1);
      if (!oos_q && xc_q == XC_LAST) oos_q <= 1'b1;
    end
  end

  assign oos = oos_q;

endmodule

// File: rtl/prbs_lock_monitor.sv
module prbs_lock_monitor
  import prbs_mon_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int LOCK_CNT = 16,
  parameter int DROP_CNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              pn_sel,
  input  logic              err_clr,
  output logic              oos,
  output logic              err_flag
);

  logic              sel_q;
  logic              type_chg;
  logic              adv;
  pn_kind_e          kind;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] exp_word;
  logic              hit_evt;
  logic              miss_evt;
  logic              err_q;

  assign kind     = pn_kind_e'(sel_q);
  assign type_chg = pn_sel != sel_q;
  assign adv      = smp_vld && !type_chg;
  assign rx_word  = (kind == PN_23) ? ~smp_data : smp_data;
  assign hit_evt  = adv && (rx_word == exp_word);
  assign miss_evt = adv && (rx_word != exp_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= pn_sel;
  end

  prbs_ref_gen #(.DATA_W(DATA_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .reseed   (oos),
    .kind     (kind),
    .rx_word  (rx_word),
    .exp_word (exp_word)
  );

  prbs_hyst #(.LOCK_CNT(LOCK_CNT), .DROP_CNT(DROP_CNT)) u_hyst (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (type_chg),
    .hit   (hit_evt),
    .miss  (miss_evt),
    .oos   (oos)
  );

  // a locked mismatch outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err_q <= 1'b0;
    else if (miss_evt && !oos) err_q <= 1'b1;
    else if (err_clr)          err_q <= 1'b0;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/prbs_mon_chk.sv
module prbs_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic err_clr,
  input logic oos,
  input logic err_flag,
  input logic hit_evt,
  input logic miss_evt
);

  // R5
  oos_rise_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oos) |-> $past(miss_evt));

  // R4
  oos_fall_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oos) |-> $past(hit_evt));

  // R7
  err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(miss_evt && !oos));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(miss_evt && !oos)) |=> !err_flag);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(oos));

  // R9
  event_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt || miss_evt) |-> smp_vld);

  // R6
  event_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_evt, miss_evt}));

endmodule

bind prbs_lock_monitor prbs_mon_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .err_clr  (err_clr),
  .oos      (oos),
  .err_flag (err_flag),
  .hit_evt  (hit_evt),
  .miss_evt (miss_evt)
);

// File: tb/sim_prbs_lock_monitor.sv
`timescale 1ns/1ps
module sim_prbs_lock_monitor;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_vld = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         pn_sel = 1'b0;
  logic         err_clr = 1'b0;
  logic         oos;
  logic         err_flag;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  prbs_lock_monitor #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .pn_sel(pn_sel), .err_clr(err_clr), .oos(oos), .err_flag(err_flag)
  );

  // ---------------- behavioural reference model ----------------
  bit           m_oos = 0, m_err = 0, m_sel = 0, m_set = 0, m_oos_n = 0;
  int           m_mc = 0, m_xc = 0;
  bit           m_hist[$];
  bit           m_tmp[$];
  bit           nb;
  logic [W-1:0] m_exp, m_rx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oos = 0; m_err = 0; m_sel = 0; m_mc = 0; m_xc = 0;
      m_hist.delete();
      repeat (23) m_hist.push_back(1'b0);
    end else begin
      m_set = 0;
      if (pn_sel != m_sel) begin
        m_sel = pn_sel; m_mc = 0; m_xc = 0;
      end else if (smp_vld) begin
        m_tmp = m_hist;
        for (int i = W - 1; i >= 0; i--) begin
          if (m_sel) nb = m_tmp[m_tmp.size()-23] ^ m_tmp[m_tmp.size()-18];
          else       nb = m_tmp[m_tmp.size()-9]  ^ m_tmp[m_tmp.size()-5];
          m_exp[i] = nb;
          m_tmp.push_back(nb);
          void'(m_tmp.pop_front());
        end
        m_rx = m_sel ? ~smp_data : smp_data;
        m_oos_n = m_oos;
        if (m_rx == m_exp) begin
          m_xc = 0; m_mc++;
          if (m_oos && m_mc == 16) m_oos_n = 0;
        end else begin
          m_mc = 0; m_xc++;
          if (!m_oos && m_xc == 64) m_oos_n = 1;
          if (!m_oos) m_set = 1;
        end
        if (m_oos) begin
          m_hist.delete();
          for (int i = 22; i >= 0; i--) m_hist.push_back(m_rx[i]);
        end else begin
          m_hist = m_tmp;
        end
        m_oos = m_oos_n;
      end
      if (m_set) m_err = 1;
      else if (err_clr) m_err = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (oos !== m_oos) begin
      failures++;
      $display("FAIL R4/R5 per-cycle oos: actual=%0b expected=%0b t=%0t", oos, m_oos, $time);
    end
    checks++;
    if (err_flag !== m_err) begin
      failures++;
      $display("FAIL R7/R8 per-cycle err_flag: actual=%0b expected=%0b t=%0t", err_flag, m_err, $time);
    end
  end

  // ---------------- stimulus helpers ----------------
  bit q9[$];
  bit q23[$];

  task automatic next_true(input bit sel, output logic [W-1:0] w);
    bit b;
    for (int i = W - 1; i >= 0; i--) begin
      if (sel) begin
        b = q23[q23.size()-23] ^ q23[q23.size()-18];
        q23.push_back(b); void'(q23.pop_front());
      end else begin
        b = q9[q9.size()-9] ^ q9[q9.size()-5];
        q9.push_back(b); void'(q9.pop_front());
      end
      w[i] = b;
    end
  endtask

  task automatic cyc(input bit v, input logic [W-1:0] d, input bit clr);
    smp_vld = v; smp_data = d; err_clr = clr;
    @(posedge clk);
    @(negedge clk);
    smp_vld = 0; err_clr = 0;
  endtask

  task automatic good(input int n, input bit inv);
    logic [W-1:0] w;
    for (int i = 0; i < n; i++) begin
      next_true(pn_sel, w);
      cyc(1, (pn_sel && inv) ? ~w : w, 0);
    end
  endtask

  task automatic bad(input int n, input bit clr);
    logic [W-1:0] w;
    for (int i = 0; i < n; i++) begin
      next_true(pn_sel, w);
      cyc(1, (pn_sel ? ~w : w) ^ W'(1), clr);
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (9) q9.push_back(1'b1);
    repeat (23) q23.push_back(1'b1);
    repeat (3) @(negedge clk);
    chk("R1 oos after reset", oos, 1'b0);
    chk("R1 err after reset", err_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // PN9 from a zero reference: 64 locked misses, then acquisition
    good(63, 1);
    chk("R5 oos after 63 misses", oos, 1'b0);
    good(1, 1);
    chk("R5 oos after 64 misses", oos, 1'b1);
    chk("R7 err set by locked misses", err_flag, 1'b1);
    good(16, 1);
    chk("R4 oos after 15 matches", oos, 1'b1);
    good(1, 1);
    chk("R2 R4 PN9 lock on 16th match", oos, 1'b0);

    cyc(0, '0, 1);
    chk("R8 err cleared", err_flag, 1'b0);
    good(20, 1);
    chk("R8 err stays clear on good PN9", err_flag, 1'b0);

    bad(1, 0);
    chk("R7 isolated locked mismatch", err_flag, 1'b1);
    chk("R7 oos unaffected", oos, 1'b0);
    cyc(0, '0, 1);
    good(5, 1);
    chk("R10 free-run after bad word", err_flag, 1'b0);

    for (int i = 0; i < 10; i++) cyc(0, W'($urandom), 0);
    good(5, 1);
    chk("R9 invalid words ignored", err_flag, 1'b0);

    bad(63, 0); good(1, 1); bad(63, 0);
    chk("R6 good word resets miss run", oos, 1'b0);
    bad(1, 0);
    chk("R5 drop on 64th miss", oos, 1'b1);

    good(15, 1); bad(1, 0); good(16, 1);
    chk("R6 R10 bad word restarts acquisition", oos, 1'b1);
    good(1, 1);
    chk("R4 relock on 16th match", oos, 1'b0);

    pn_sel = 1'b1;
    cyc(0, '0, 0);
    good(80, 0);
    chk("R3 uninverted PN23 never locks", oos, 1'b1);
    good(20, 1);
    chk("R3 inverted PN23 locks", oos, 1'b0);

    cyc(0, '0, 1);
    bad(1, 1);
    chk("R8 locked miss beats clear", err_flag, 1'b1);
    bad(9, 0);
    pn_sel = 1'b0; cyc(1, W'($urandom), 0);
    pn_sel = 1'b1; cyc(1, W'($urandom), 0);
    bad(60, 0);
    chk("R11 type change restarts miss run", oos, 1'b0);
    bad(4, 0);
    chk("R11 drop after 64 fresh misses", oos, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule